// File: doc/BRIEF.md
# Pin-Multiplexed General-Purpose I/O Port

This block is one parallel I/O port of `PINS` pads, configured through five word registers on a simple synchronous register bus. For every pad it decides who drives it: the port itself, as a general-purpose input or output, or one of two dedicated peripheral functions. Each pad can also switch from push-pull drive to open-drain drive. In open-drain mode the pad only pulls low and is otherwise left at high impedance, so several pads can share a wired-OR net.

The pad side is three vectors: the value to drive, the enable for the three-state pad buffer, and the sampled pad level. The two peripheral functions connect through plain per-pin value and enable inputs. Both receive the synchronized pad level on their input vectors. Software reads the data register to see the state of the pins. Input pins and peripheral pins return the synchronized pad level. GPIO output pins return the value that was last written.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, every configuration register reads 0 and `pad_oe` is all zeros, so every pin is a floating general-purpose input.
- R2: Word addresses are: 0 data, 1 direction, 2 open-drain, 3 assignment, 4 option. A read request returns its data on `bus_rdata` with `bus_rvalid` high one cycle later. Writes never raise `bus_rvalid`. Addresses 5 to 7, and register bits at or above `PINS`, read as 0. Writes to addresses 5 to 7 have no effect.
- R3: A write changes only the bytes whose `bus_be` bit is 1. Strobe bit k covers data bits 8k to 8k+7.
- R4: A pin with assignment bit 0, direction bit 1 and open-drain bit 0 has `pad_oe` 1, and `pad_out` equal to its data bit.
- R5: A pin with assignment bit 0 and direction bit 0 has `pad_oe` 0.
- R6: With its open-drain bit at 1, a pin never drives high. `pad_out` is 0, and `pad_oe` is 1 exactly when the pin would otherwise drive a 0. This holds in both GPIO and peripheral mode.
- R7: Reading the data register returns the stored data bit for GPIO output pins. All other pins return the pad level after a two-flop synchronizer. A pad change made just before clock edge n is visible to a read request sampled at edge n+2, and not to one sampled at edge n+1.
- R8: A pin with assignment bit 1 takes its drive value and enable from `alt1_out`/`alt1_oe` when its option bit is 0. It takes them from `alt2_out`/`alt2_oe` when its option bit is 1.
- R9: For a peripheral pin, direction bit 0 passes the selected peripheral's enable to the pad. Direction bit 1 forces the enable on.
- R10: `alt1_in` and `alt2_in` both carry the synchronized pad level for every pin, in every mode. Each updates two clock edges after a pad change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address of the register |
| bus_be | input | DW/8 | Byte strobes for writes |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | PINS | Pad level from the pad receivers |
| pad_out | output | PINS | Value driven onto each pad |
| pad_oe | output | PINS | Pad driver enable |
| alt1_out | input | PINS | Peripheral option 1 drive value |
| alt1_oe | input | PINS | Peripheral option 1 drive enable |
| alt1_in | output | PINS | Synchronized pad level to peripheral option 1 |
| alt2_out | input | PINS | Peripheral option 2 drive value |
| alt2_oe | input | PINS | Peripheral option 2 drive enable |
| alt2_in | output | PINS | Synchronized pad level to peripheral option 2 |

## Verification
The situation hardest to reach from the ports is the exact edge at which a pad change becomes visible through the synchronizer. The bench reaches it by changing `pad_in` on a falling edge and starting a read on the very next falling edge, which must still return the old level. A second read, issued after the next edge, must return the new level. The bench also builds a mix of peripheral pins covering both options, both directions, and both drive modes in one configuration. This combination shows the open-drain gating applied to peripheral-sourced values and enables, and not only to the data register.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int PINS = 16,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  input  logic [PINS-1:0] alt1_out,
  input  logic [PINS-1:0] alt1_oe,
  output logic [PINS-1:0] alt1_in,
  input  logic [PINS-1:0] alt2_out,
  input  logic [PINS-1:0] alt2_oe,
  output logic [PINS-1:0] alt2_in
);
  localparam int NREG = 5;

  logic [PINS-1:0] cfg_q [NREG];
  logic [PINS-1:0] wmask, sync1_q, sync2_q;
  logic [PINS-1:0] dat_q, dir_q, od_q, asg_q, opt_q;
  logic [PINS-1:0] gpio_out, sel_val, sel_en, drv_val, drv_en, rd_data;
  logic [PINS-1:0] rd_val;
  logic            unused_hi;

  assign unused_hi = ^{bus_wdata, bus_be};

  always_comb
    for (int i = 0; i < PINS; i++) wmask[i] = bus_be[i/8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) cfg_q[r] <= '0;
    end else if (bus_sel && bus_we) begin
      for (int r = 0; r < NREG; r++)
        if (bus_addr == AW'(r))
          cfg_q[r] <= (cfg_q[r] & ~wmask) | (bus_wdata[PINS-1:0] & wmask);
    end

  assign dat_q = cfg_q[0];
  assign dir_q = cfg_q[1];
  assign od_q  = cfg_q[2];
  assign asg_q = cfg_q[3];
  assign opt_q = cfg_q[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end

  assign alt1_in = sync2_q;
  assign alt2_in = sync2_q;

  assign gpio_out = ~asg_q & dir_q;
  assign sel_val  = (opt_q & alt2_out) | (~opt_q & alt1_out);
  assign sel_en   = (opt_q & alt2_oe)  | (~opt_q & alt1_oe);
  assign drv_val  = (asg_q & sel_val) | (~asg_q & dat_q);
  assign drv_en   = (asg_q & (dir_q | sel_en)) | gpio_out;
  assign pad_out  = drv_val & ~od_q;
  assign pad_oe   = drv_en & (~od_q | ~drv_val);
  assign rd_data  = (gpio_out & dat_q) | (~gpio_out & sync2_q);

  always_comb
    case (bus_addr)
      AW'(0):  rd_val = rd_data;
      AW'(1):  rd_val = dir_q;
      AW'(2):  rd_val = od_q;
      AW'(3):  rd_val = asg_q;
      AW'(4):  rd_val = opt_q;
      default: rd_val = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_sel && !bus_we;
      if (bus_sel && !bus_we) bus_rdata <= DW'(rd_val);
    end

  p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & pad_oe & pad_out) == '0);
  p_gpio_in_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~asg_q & ~dir_q & pad_oe) == '0);
  p_gpio_pp_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (~asg_q & dir_q & ~od_q & ~pad_oe) == '0);
  p_periph_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_q & dir_q & ~od_q & ~pad_oe) == '0);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> bus_rvalid);
  p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> !bus_rvalid);
  p_sync_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sync1_q) |=> $stable(alt1_in));
endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 16;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW/8-1:0] bus_be = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [PINS-1:0] pad_in = '0, pad_out, pad_oe;
  logic [PINS-1:0] alt1_out = '0, alt1_oe = '0, alt1_in;
  logic [PINS-1:0] alt2_out = '0, alt2_oe = '0, alt2_in;
  int checks = 0, errors = 0;

  gpio_mux_port #(.PINS(PINS), .DW(DW), .AW(AW)) i_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt1_out(alt1_out),
    .alt1_oe(alt1_oe), .alt1_in(alt1_in), .alt2_out(alt2_out),
    .alt2_oe(alt2_oe), .alt2_in(alt2_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_be = be; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R2 no rvalid on write", 32'(bus_rvalid), 0);
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R2 rvalid after read", 32'(bus_rvalid), 1);
    data = bus_rdata;
  endtask

  task automatic cfg(logic [15:0] d, logic [15:0] dr, logic [15:0] od, logic [15:0] as, logic [15:0] op);
    wr(0, 32'(d)); wr(1, 32'(dr)); wr(2, 32'(od)); wr(3, 32'(as)); wr(4, 32'(op));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pad_oe at reset", 32'(pad_oe), 0);
    for (int a = 1; a < 5; a++) begin
      rd(a, v);
      chk("R1 config reset", v, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(1, 32'hFFFF_A5A5);
    rd(1, v); chk("R2 direction readback, upper bits zero", v, 32'h0000_A5A5);
    wr(4, 32'h0000_3C3C);
    rd(4, v); chk("R2 option readback", v, 32'h0000_3C3C);
    wr(6, 32'hFFFF_FFFF);
    rd(6, v); chk("R2 unmapped address reads zero", v, 0);
    rd(1, v); chk("R2 unmapped write leaves direction", v, 32'h0000_A5A5);
    rd(4, v); chk("R2 unmapped write leaves option", v, 32'h0000_3C3C);
  endtask

  task automatic t_bytes();
    logic [31:0] v;
    wr(2, 32'h0);
    wr(2, 32'h0000_FFFF, 4'b0010);
    rd(2, v); chk("R3 upper byte only", v, 32'h0000_FF00);
    wr(2, 32'h0000_0000, 4'b1101);
    rd(2, v); chk("R3 masked byte kept", v, 32'h0000_FF00);
  endtask

  task automatic t_gpio();
    cfg(16'h0F0F, 16'h00FF, 16'h0000, 16'h0000, 16'h0000);
    @(negedge clk);
    chk("R4/R5 push-pull enables", 32'(pad_oe), 32'h0000_00FF);
    chk("R4 push-pull value", 32'(pad_out & pad_oe), 32'h0000_000F);
    wr(2, 32'h0000_FFFF);
    @(negedge clk);
    chk("R6 open-drain enables", 32'(pad_oe), 32'h0000_00F0);
    chk("R6 open-drain never high", 32'(pad_out), 0);
  endtask

  task automatic t_sync();
    pad_in = 16'h1111;
    repeat (3) @(negedge clk);
    chk("R10 settled level", 32'(alt1_in), 32'h1111);
    pad_in = 16'h2222;
    @(negedge clk);
    chk("R10 one edge still old", 32'(alt2_in), 32'h1111);
    @(negedge clk);
    chk("R10 alt1 after two edges", 32'(alt1_in), 32'h2222);
    chk("R10 alt2 after two edges", 32'(alt2_in), 32'h2222);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    cfg(16'h0F0F, 16'h00FF, 16'h0000, 16'h0000, 16'h0000);
    pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R7 mixed readback", v, 32'h0000_120F);
    pad_in = 16'hABCD;
    rd(0, v); chk("R7 read one edge after change is old", v, 32'h0000_120F);
    rd(0, v); chk("R7 read after two edges is new", v, 32'h0000_AB0F);
  endtask

  task automatic t_periph();
    logic [31:0] v;
    alt1_out = 16'hAAAA; alt1_oe = 16'h0F0F;
    alt2_out = 16'h5555; alt2_oe = 16'h3333;
    pad_in = 16'h6789;
    cfg(16'h0F0F, 16'h000F, 16'h0000, 16'hFFFF, 16'hFF00);
    @(negedge clk);
    chk("R8 peripheral value", 32'(pad_out), 32'h0000_55AA);
    chk("R9 peripheral enables", 32'(pad_oe), 32'h0000_330F);
    rd(0, v); chk("R7 peripheral pins read pad", v, 32'h0000_6789);
    wr(2, 32'h0000_FFFF);
    @(negedge clk);
    chk("R6 peripheral open-drain enables", 32'(pad_oe), 32'h0000_2205);
    chk("R6 peripheral open-drain low", 32'(pad_out), 0);
    chk("R10 input in peripheral mode", 32'(alt1_in), 32'h6789);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_bytes();
    t_gpio();
    t_sync();
    t_readback();
    t_periph();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule